// File: doc/BRIEF.md
# Rail-Monitored Processor Reset Generator

This block holds a processor in reset according to the state of one regulated supply rail. It takes two inputs. The first is the rail enable. The second is the raw output of an analog comparator that reads high once the rail is at or above 87 % of its regulation voltage. The reset output is open-drain style, so it is modelled as an active-high pull-down enable, `pull_low`. The level the reset line takes is also brought out as `reset_line_n`. The block runs on a slow clock. The comparator result passes through a synchronizer first. A timeout counter then measures how long the rail has been usable without a break.

A finite-state machine has three states. HOLD keeps reset asserted while the rail is unusable. COUNT keeps reset asserted while the timeout runs. RELEASE lets the line go high. It has four transitions. *qualify* goes from HOLD to COUNT on the first usable sample. *abort* goes from COUNT back to HOLD when a sample is not usable, which clears the counter. *expire* goes from HOLD or COUNT to RELEASE on the sample that completes the timeout. *fault* goes from RELEASE to HOLD when a sample is not usable. Reset is applied at once: a disabled rail pulls the line low combinationally. Reset is released only after `TIMEOUT_CYC` usable samples in a row. `TIMEOUT_CYC` is the timeout in clock cycles. In use it is set to give a typical 60 ms, and never less than 30 ms. It must be at least 1. `SYNC_STAGES` is the synchronizer depth and must also be at least 1.

Top module: `rail_reset_gen`

## Requirements
- R1: While `rst_n` is low, and after it rises until a release, `pull_low` is 1.
- R2: The power-good input is retimed through `SYNC_STAGES` flip-flops. If `rail_good_raw` rises before clock edge 1 and `rail_en` is high, edge `SYNC_STAGES+1` is the first edge that counts toward the timeout.
- R3: With the rail enabled and power-good held high from edge 1, `pull_low` stays 1 through edge `SYNC_STAGES+TIMEOUT_CYC-1`. It becomes 0 after edge `SYNC_STAGES+TIMEOUT_CYC`.
- R4: After a release, if `rail_good_raw` falls before edge 1, `pull_low` returns to 1 after edge `SYNC_STAGES+1`.
- R5: Whenever `rail_en` is 0, `pull_low` is 1 without waiting for a clock edge, whatever the power-good input does.
- R6: A clock edge that sees the rail disabled during the timeout clears the count. Release then needs a full `TIMEOUT_CYC` further usable edges, counted from the next edge with the rail enabled.
- R7: `reset_line_n` is always the logical inverse of `pull_low`: 0 means the line is pulled low.
- R8: A power-good pulse lasting fewer than `TIMEOUT_CYC` clock edges never releases reset. A pulse of g ≥ `TIMEOUT_CYC` edges releases reset from edge `SYNC_STAGES+TIMEOUT_CYC` through edge `SYNC_STAGES+g`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timing clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| rail_en | input | 1 | Monitored rail enable, synchronous to `clk` |
| rail_good_raw | input | 1 | Asynchronous comparator result, 1 when the rail is at or above 87 % of regulation |
| pull_low | output | 1 | 1 enables the open-drain pull-down on the reset line |
| reset_line_n | output | 1 | Modelled reset line level, 0 when pulled low |

## Verification
The hardest case to reach from the ports is an interruption of the timeout at a chosen count. The interruption is a single edge that sees the rail disabled or power-good low, and it must land before expiry. The bench sweeps the length of a power-good pulse from one edge up to beyond the timeout. It also sweeps the edge at which a one-cycle enable dropout lands inside the count. For every edge of each run, it computes the expected output from the pulse length, the dropout position, the synchronizer depth and the timeout.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_RELEASE = 2'd2
    } rg_state_t;
endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rstgen_timer.sv
module rstgen_timer #(
    parameter int TIMEOUT_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic expired
);
    localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (inc)    cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LAST);
endmodule

// File: rtl/rstgen_fsm.sv
module rstgen_fsm
    import rstgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rail_en,
    input  logic good_s,
    input  logic expired,
    output logic tmr_clr,
    output logic tmr_inc,
    output logic pull_low
);
    rg_state_t state, state_nx;
    logic      usable;

    assign usable = rail_en & good_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        tmr_clr  = 1'b0;
        tmr_inc  = 1'b0;
        unique case (state)
            ST_HOLD, ST_COUNT: begin
                if (!usable) begin
                    state_nx = ST_HOLD;
                    tmr_clr  = 1'b1;
                end else if (expired) begin
                    state_nx = ST_RELEASE;
                    tmr_clr  = 1'b1;
                end else begin
                    state_nx = ST_COUNT;
                    tmr_inc  = 1'b1;
                end
            end
            ST_RELEASE: begin
                tmr_clr = 1'b1;
                if (!usable) state_nx = ST_HOLD;
            end
            default: begin
                state_nx = ST_HOLD;
                tmr_clr  = 1'b1;
            end
        endcase
    end

    always_comb begin
        pull_low = 1'b1;
        unique case (state)
            ST_HOLD:    pull_low = 1'b1;
            ST_COUNT:   pull_low = 1'b1;
            ST_RELEASE: pull_low = ~rail_en;
            default:    pull_low = 1'b1;
        endcase
    end
endmodule

// File: rtl/rail_reset_gen.sv
module rail_reset_gen #(
    parameter int TIMEOUT_CYC = 1920,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rail_en,
    input  logic rail_good_raw,
    output logic pull_low,
    output logic reset_line_n
);
    logic good_s;
    logic expired;
    logic tmr_clr;
    logic tmr_inc;

    rstgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rail_good_raw),
        .dout (good_s)
    );

    rstgen_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .inc    (tmr_inc),
        .expired(expired)
    );

    rstgen_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .rail_en (rail_en),
        .good_s  (good_s),
        .expired (expired),
        .tmr_clr (tmr_clr),
        .tmr_inc (tmr_inc),
        .pull_low(pull_low)
    );

    assign reset_line_n = ~pull_low;
endmodule

// File: rtl/rstgen_chk.sv
module rstgen_chk #(
    parameter int TIMEOUT_CYC = 1920
) (
    input logic clk,
    input logic rst_n,
    input logic rail_en,
    input logic good_s,
    input logic pull_low
);
    localparam int RW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [RW-1:0] RMAX = RW'(TIMEOUT_CYC);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 run_q <= '0;
        else if (!(rail_en && good_s)) run_q <= '0;
        else if (run_q != RMAX)     run_q <= run_q + 1'b1;
    end

    AST_SHORT_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q < RMAX) |-> pull_low); // R8

    AST_FULL_RUN_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == RMAX && rail_en) |-> !pull_low); // R3

    AST_BAD_SAMPLE_REASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
        !(rail_en && good_s) |=> pull_low); // R4

    AST_DISABLED_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
        !rail_en |-> pull_low); // R5
endmodule

bind rail_reset_gen rstgen_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rail_en (rail_en),
    .good_s  (good_s),
    .pull_low(pull_low)
);

// File: tb/rail_reset_gen_tb.sv
module rail_reset_gen_tb;
    localparam int T = 5;
    localparam int S = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rail_en = 1'b0;
    logic rail_good_raw = 1'b0;
    logic pull_low;
    logic reset_line_n;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    rail_reset_gen #(.TIMEOUT_CYC(T), .SYNC_STAGES(S)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rail_en      (rail_en),
        .rail_good_raw(rail_good_raw),
        .pull_low     (pull_low),
        .reset_line_n (reset_line_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_out(input string req, input logic exp);
        chk(req, pull_low, exp);
        chk("R7", reset_line_n, ~exp);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle_hold();
        rail_good_raw = 1'b0;
        rail_en = 1'b1;
        for (int i = 0; i < S + 3; i++) step();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            step();
            chk_out("R1", 1'b1);
        end
        rst_n = 1'b1;
        step();
        chk_out("R1", 1'b1);

        // R2 R3 R4 R8: sweep power-good pulse length g
        for (int g = 1; g <= T + 3; g++) begin
            settle_hold();
            rail_good_raw = 1'b1;
            for (int k = 1; k <= g + S + 3; k++) begin
                step();
                if (g >= T && k >= S + T && k <= g + S)
                    chk_out((g < T) ? "R8" : (k == S + T) ? "R3" : "R2", 1'b0);
                else
                    chk_out((k > g + S) ? "R4" : "R8", 1'b1);
                if (k == g) rail_good_raw = 1'b0;
            end
        end

        // R6: one-edge enable dropout at edge p during the timeout
        for (int p = 2; p <= T; p++) begin
            rail_en = 1'b0;
            rail_good_raw = 1'b1;
            for (int i = 0; i < S + 2; i++) step();
            rail_en = 1'b1;
            for (int k = 1; k <= p + T + 1; k++) begin
                if (k == p) begin
                    rail_en = 1'b0;
                    #1;
                    chk_out("R5", 1'b1);
                end
                step();
                if (k == p) rail_en = 1'b1;
                chk_out("R6", (k >= p + T) ? 1'b0 : 1'b1);
            end
            // R5: immediate assertion on disable while released
            rail_en = 1'b0;
            #1;
            chk_out("R5", 1'b1);
            for (int i = 0; i < 2 * T; i++) begin
                rail_good_raw = i[0];
                step();
                chk_out("R5", 1'b1);
            end
            rail_good_raw = 1'b1;
            step();
        end

        // R1: asynchronous reset while released
        rail_en = 1'b1;
        rail_good_raw = 1'b1;
        for (int i = 0; i < S + T + 2; i++) step();
        chk_out("R3", 1'b0);
        rst_n = 1'b0;
        #1;
        chk_out("R1", 1'b1);
        step();
        rst_n = 1'b1;
        for (int k = 1; k <= S + T + 1; k++) begin
            step();
            chk_out("R1", (k >= S + T) ? 1'b0 : 1'b1);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule